// File: doc/BRIEF.md
# Branch, Call and Stack Sequencer

This block runs the multi-cycle control-transfer and stack operations of a small 8-bit processor with a 16-bit address space. The decoder starts it with a three-bit operation code, a three-bit condition selector, the zero and carry flags, and the current program counter, stack pointer and register-pair value. The block then works through a fixed byte sequence on one byte-wide memory port that has separate read and write strobes. It fetches immediate operand bytes at the program counter and moves return addresses and register pairs through a stack that grows downward.

When an operation finishes, the block raises a one-cycle completion pulse. At that point the new program counter and stack pointer are valid. For a pop it also presents the loaded pair with a write-enable, and for a return from interrupt it requests that interrupts be enabled. A taken transfer spends one extra idle cycle before it completes. A transfer whose condition fails leaves as early as its sequence allows. Only one operation is in flight at a time.

Top module: `flow_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `pc_out` and `sp_out` are zero, and `done`, `busy`, `mem_rd` and `mem_wr` are all low.
- R2: `cond` selects the branch condition: 0 = always, 1 = carry set, 2 = zero set, 3 = carry clear, 4 = zero clear, and 5 to 7 = always. The flags are sampled when the operation is accepted.
- R3: Absolute jump (op 0) reads the low target byte at PC and then the high byte at PC+1. If taken, PC becomes the target and `done` rises in the 4th cycle after acceptance. If not taken, PC becomes PC+2 and `done` rises in the 3rd cycle.
- R4: Relative jump (op 1) reads one byte at PC. If taken, PC becomes PC+1 plus that byte read as a signed value, with `done` in the 3rd cycle. If not taken, PC becomes PC+1 with `done` in the 2nd cycle.
- R5: Pair jump (op 2) sets PC to `pair_in`, makes no memory access, and raises `done` in the 1st cycle.
- R6: Taken call (op 3) writes byte 0 of PC+2 at SP-2, then byte 1 at SP-1. It then reads the target low and high bytes at PC and PC+1, sets SP to SP-2 and raises `done` in the 6th cycle. An untaken call performs only the two reads, sets PC to PC+2, leaves SP unchanged and raises `done` in the 3rd cycle.
- R7: Return (op 4) reads the low byte at SP. If taken, it reads the high byte at SP+1, loads PC, sets SP to SP+2 and raises `done` in the 4th cycle. If not taken, PC and SP are unchanged and `done` rises in the 2nd cycle.
- R8: Return from interrupt (op 5) ignores `cond`, always behaves as a taken return, and raises `ie_set` in the same cycle as `done` and in no other.
- R9: Push (op 6) writes the high byte of `pair_in` at SP-1, then the low byte at SP-2, sets SP to SP-2 and raises `done` in the 4th cycle.
- R10: Pop (op 7) reads the low byte at SP and the high byte at SP+1, sets SP to SP+2 and raises `done` in the 3rd cycle, with `pair_we` high and `pair_out` holding the pair. When `flags_pair` is 1, bits 3:0 of the low byte are forced to zero.
- R11: All PC and SP arithmetic, including memory addresses, wraps modulo 65536.
- R12: `done` lasts exactly one cycle, after which `busy` is low. A `start` that arrives while `busy` is high is ignored and does not change the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept an operation when idle |
| op | input | 3 | Operation code |
| cond | input | 3 | Condition selector |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flags_pair | input | 1 | Popped pair is accumulator+flags |
| pc_in | input | 16 | PC at the first immediate byte |
| sp_in | input | 16 | Current stack pointer |
| pair_in | input | 16 | Pair to push or jump target |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the strobe cycle |
| pair_out | output | 16 | Popped pair |
| pair_we | output | 1 | Write-back enable for `pair_out` |
| ie_set | output | 1 | Interrupt-enable request |

## Verification
A wrong state transition shows up within a few cycles as a changed completion latency, or as a memory access that is missing, extra or out of order. The bench compares each access, including strobe type, address and write data, against a sequence it builds itself. A wrongly committed PC or SP is visible at `done`. The one-cycle idle gap after a taken transfer and the early exit after a failed condition appear only as latency, so the completion cycle is checked for every operation, condition and flag combination.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [2:0] {
        OP_JABS  = 3'd0,
        OP_JREL  = 3'd1,
        OP_JPAIR = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_RETI  = 3'd5,
        OP_PUSH  = 3'd6,
        OP_POP   = 3'd7
    } xfer_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUT0,
        ST_PUT1,
        ST_GET0,
        ST_GET1,
        ST_GAP,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        xfer_op_e op;
        logic     taken;
        logic     flag_pop;
    } job_t;

    // Low-nibble clear applied to a popped flags byte.
    localparam int FLAG_LOW_BITS = 4;

endpackage

// File: rtl/flow_cond.sv
module flow_cond (
    input  logic [2:0] sel,
    input  logic       zf,
    input  logic       cf,
    output logic       ok
);
    always_comb begin
        case (sel)
            3'd1:    ok = cf;
            3'd2:    ok = zf;
            3'd3:    ok = !cf;
            3'd4:    ok = !zf;
            default: ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/flow_mem_port.sv
module flow_mem_port
    import flow_pkg::*;
#(
    parameter int DW = 8
) (
    input  seq_state_e        st,
    input  xfer_op_e          op,
    input  logic [2*DW-1:0]   pc,
    input  logic [2*DW-1:0]   sp,
    input  logic [2*DW-1:0]   pair,
    output logic [2*DW-1:0]   addr,
    output logic              rd,
    output logic              wr,
    output logic [DW-1:0]     wdata
);
    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] ret_addr;
    logic          stack_src;

    assign ret_addr  = pc + TWO;
    assign stack_src = (op == OP_RET) || (op == OP_RETI) || (op == OP_POP);

    always_comb begin
        addr  = '0;
        rd    = 1'b0;
        wr    = 1'b0;
        wdata = '0;
        case (st)
            ST_PUT0: begin
                wr = 1'b1;
                if (op == OP_CALL) begin
                    addr  = sp - TWO;
                    wdata = ret_addr[DW-1:0];
                end else begin
                    addr  = sp - ONE;
                    wdata = pair[AW-1:DW];
                end
            end
            ST_PUT1: begin
                wr = 1'b1;
                if (op == OP_CALL) begin
                    addr  = sp - ONE;
                    wdata = ret_addr[AW-1:DW];
                end else begin
                    addr  = sp - TWO;
                    wdata = pair[DW-1:0];
                end
            end
            ST_GET0: begin
                rd   = 1'b1;
                addr = stack_src ? sp : pc;
            end
            ST_GET1: begin
                rd   = 1'b1;
                addr = stack_src ? (sp + ONE) : (pc + ONE);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import flow_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [2:0]        cond,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flags_pair,
    input  logic [2*DW-1:0]   pc_in,
    input  logic [2*DW-1:0]   sp_in,
    input  logic [2*DW-1:0]   pair_in,
    output logic              busy,
    output logic              done,
    output logic [2*DW-1:0]   pc_out,
    output logic [2*DW-1:0]   sp_out,
    output logic [2*DW-1:0]   mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [2*DW-1:0]   pair_out,
    output logic              pair_we,
    output logic              ie_set
);
    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);
    localparam logic [DW-1:0] FLAG_MASK = {{(DW-FLAG_LOW_BITS){1'b1}}, {FLAG_LOW_BITS{1'b0}}};

    seq_state_e    st;
    job_t          job;
    logic [AW-1:0] pc_r, sp_r, pair_r;
    logic [DW-1:0] lo_r;
    logic          cond_ok;
    logic [AW-1:0] rel_target;
    logic [AW-1:0] joined;

    flow_cond u_cond (
        .sel (cond),
        .zf  (flag_z),
        .cf  (flag_c),
        .ok  (cond_ok)
    );

    flow_mem_port #(.DW(DW)) u_port (
        .st    (st),
        .op    (job.op),
        .pc    (pc_r),
        .sp    (sp_r),
        .pair  (pair_r),
        .addr  (mem_addr),
        .rd    (mem_rd),
        .wr    (mem_wr),
        .wdata (mem_wdata)
    );

    assign rel_target = pc_r + ONE + {{DW{mem_rdata[DW-1]}}, mem_rdata};
    assign joined     = {mem_rdata, lo_r};

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            job    <= '0;
            pc_r   <= '0;
            sp_r   <= '0;
            pair_r <= '0;
            lo_r   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    job.op       <= xfer_op_e'(op);
                    job.taken    <= (op == OP_RETI) ? 1'b1 : cond_ok;
                    job.flag_pop <= flags_pair;
                    pc_r         <= pc_in;
                    sp_r         <= sp_in;
                    pair_r       <= pair_in;
                    case (xfer_op_e'(op))
                        OP_JPAIR: begin
                            pc_r <= pair_in;
                            st   <= ST_FIN;
                        end
                        OP_CALL:  st <= cond_ok ? ST_PUT0 : ST_GET0;
                        OP_PUSH:  st <= ST_PUT0;
                        default:  st <= ST_GET0;
                    endcase
                end
                ST_PUT0: st <= ST_PUT1;
                ST_PUT1: begin
                    if (job.op == OP_PUSH) begin
                        sp_r <= sp_r - TWO;
                        st   <= ST_GAP;
                    end else begin
                        st   <= ST_GET0;
                    end
                end
                ST_GET0: begin
                    lo_r <= mem_rdata;
                    if (job.op == OP_JREL) begin
                        pc_r <= job.taken ? rel_target : (pc_r + ONE);
                        st   <= job.taken ? ST_GAP : ST_FIN;
                    end else if (job.op == OP_RET && !job.taken) begin
                        st   <= ST_FIN;
                    end else begin
                        st   <= ST_GET1;
                    end
                end
                ST_GET1: begin
                    case (job.op)
                        OP_RET, OP_RETI: begin
                            pc_r <= joined;
                            sp_r <= sp_r + TWO;
                            st   <= ST_GAP;
                        end
                        OP_POP: begin
                            pair_r <= {mem_rdata, job.flag_pop ? (lo_r & FLAG_MASK) : lo_r};
                            sp_r   <= sp_r + TWO;
                            st     <= ST_FIN;
                        end
                        default: begin
                            if (job.taken) begin
                                pc_r <= joined;
                                if (job.op == OP_CALL)
                                    sp_r <= sp_r - TWO;
                                st   <= ST_GAP;
                            end else begin
                                pc_r <= pc_r + TWO;
                                st   <= ST_FIN;
                            end
                        end
                    endcase
                end
                ST_GAP:  st <= ST_FIN;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_FIN);
    assign pc_out   = pc_r;
    assign sp_out   = sp_r;
    assign pair_out = pair_r;
    assign pair_we  = done && (job.op == OP_POP);
    assign ie_set   = done && (job.op == OP_RETI);

    // R12: completion is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: the two strobes never overlap
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R5: nothing touches memory while the sequencer is idle
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr));

    // R9: the second push write lands one byte below the first
    a_r9_push_descends: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $past(mem_wr) && job.op == OP_PUSH) |-> (mem_addr == $past(mem_addr) - ONE));

    // R6: the second call write lands one byte above the first
    a_r6_call_ascends: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $past(mem_wr) && job.op == OP_CALL) |-> (mem_addr == $past(mem_addr) + ONE));

    // R8: interrupt-enable request only with completion
    a_r8_ie_with_done: assert property (@(posedge clk) disable iff (rst)
        ie_set |-> done);

    // R10: pair write-back only with completion
    a_r10_we_with_done: assert property (@(posedge clk) disable iff (rst)
        pair_we |-> done);

endmodule

// File: tb/sim_flow_seq.sv
module sim_flow_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_i = '0, cond_i = '0;
    logic        zf = 1'b0, cf = 1'b0, fsel = 1'b0;
    logic [15:0] pc_i = '0, sp_i = '0, pair_i = '0;
    logic        busy, done, mem_rd, mem_wr, pair_we, ie_set;
    logic [15:0] pc_o, sp_o, mem_addr, pair_o;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  mem [0:255];

    int errs = 0;
    int total = 0;

    bit          ew [8];
    logic [15:0] ea [8];
    logic [7:0]  ed [8];
    int          ne;
    bit          aw [8];
    logic [15:0] aa [8];
    logic [7:0]  ad [8];
    int          na;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    flow_seq u0 (
        .clk(clk), .rst(rst), .start(start), .op(op_i), .cond(cond_i),
        .flag_z(zf), .flag_c(cf), .flags_pair(fsel),
        .pc_in(pc_i), .sp_in(sp_i), .pair_in(pair_i),
        .busy(busy), .done(done), .pc_out(pc_o), .sp_out(sp_o),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pair_out(pair_o), .pair_we(pair_we), .ie_set(ie_set)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd37;
        return p + 8'd11;
    endfunction

    function automatic string tag_of(input int o);
        case (o)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add_exp(input bit w, input logic [15:0] a, input logic [7:0] d);
        ew[ne] = w;
        ea[ne] = a;
        ed[ne] = w ? d : 8'h00;
        ne++;
    endtask

    task automatic run_op(input int o, input int c, input bit z, input bit cy, input bit fl,
                          input bit poke, input logic [15:0] pc, input logic [15:0] sp,
                          input logic [15:0] pr, input string tag);
        bit tk, eie, ewe, gie, gwe, pk;
        int elat, lat;
        logic [15:0] epc, esp, epair, ret, gpc, gsp, gpair;
        logic [7:0] off;
        for (int i = 0; i < 256; i++) mem[i] = pat(16'(i));
        case (c)
            1: tk = cy;
            2: tk = z;
            3: tk = !cy;
            4: tk = !z;
            default: tk = 1'b1;
        endcase
        if (o == 5) tk = 1'b1;
        pk = poke && (o != 2);
        ne = 0; na = 0;
        epc = pc; esp = sp; epair = pr; eie = 1'b0; ewe = 1'b0; elat = 0;
        ret = pc + 16'd2;
        case (o)
            0: begin
                add_exp(0, pc, 0); add_exp(0, pc + 16'd1, 0);
                if (tk) begin epc = {pat(pc + 16'd1), pat(pc)}; elat = 4; end
                else    begin epc = pc + 16'd2; elat = 3; end
            end
            1: begin
                add_exp(0, pc, 0);
                off = pat(pc);
                if (tk) begin epc = pc + 16'd1 + {{8{off[7]}}, off}; elat = 3; end
                else    begin epc = pc + 16'd1; elat = 2; end
            end
            2: begin epc = pr; elat = 1; end
            3: begin
                if (tk) begin
                    add_exp(1, sp - 16'd2, ret[7:0]);
                    add_exp(1, sp - 16'd1, ret[15:8]);
                    add_exp(0, pc, 0); add_exp(0, pc + 16'd1, 0);
                    epc = {pat(pc + 16'd1), pat(pc)}; esp = sp - 16'd2; elat = 6;
                end else begin
                    add_exp(0, pc, 0); add_exp(0, pc + 16'd1, 0);
                    epc = pc + 16'd2; elat = 3;
                end
            end
            4, 5: begin
                add_exp(0, sp, 0);
                if (tk) begin
                    add_exp(0, sp + 16'd1, 0);
                    epc = {pat(sp + 16'd1), pat(sp)}; esp = sp + 16'd2; elat = 4;
                end else elat = 2;
                eie = (o == 5);
            end
            6: begin
                add_exp(1, sp - 16'd1, pr[15:8]);
                add_exp(1, sp - 16'd2, pr[7:0]);
                esp = sp - 16'd2; elat = 4;
            end
            default: begin
                add_exp(0, sp, 0); add_exp(0, sp + 16'd1, 0);
                epair = {pat(sp + 16'd1), fl ? (pat(sp) & 8'hF0) : pat(sp)};
                esp = sp + 16'd2; elat = 3; ewe = 1'b1;
            end
        endcase

        @(negedge clk);
        start = 1'b1; op_i = 3'(o); cond_i = 3'(c); zf = z; cf = cy; fsel = fl;
        pc_i = pc; sp_i = sp; pair_i = pr;
        @(negedge clk);
        if (pk) begin
            op_i = 3'd2; pair_i = 16'hBEEF; pc_i = 16'h0BAD; sp_i = 16'h0BAD;
        end else start = 1'b0;
        lat = 0; gpc = '0; gsp = '0; gpair = '0; gie = 1'b0; gwe = 1'b0;
        for (int n = 1; n <= 20; n++) begin
            if (n == 2) start = 1'b0;
            if (mem_rd || mem_wr) begin
                if (na < 8) begin
                    aw[na] = mem_wr; aa[na] = mem_addr; ad[na] = mem_wr ? mem_wdata : 8'h00;
                end
                na++;
                if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
            end
            if (done) begin
                lat = n; gpc = pc_o; gsp = sp_o; gpair = pair_o; gie = ie_set; gwe = pair_we;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(tag, "completion cycle", 32'(lat), 32'(elat));
        if (o == 0 || o == 1 || o == 3 || o == 4)
            chk("R2", "pc after condition", 32'(gpc), 32'(epc));
        chk(tag, "access count", 32'(na), 32'(ne));
        for (int i = 0; i < ne && i < na && i < 8; i++)
            chk(tag, "access kind/addr/data", {7'd0, aw[i], aa[i], ad[i]}, {7'd0, ew[i], ea[i], ed[i]});
        chk(tag, "pc_out", 32'(gpc), 32'(epc));
        chk(tag, "sp_out", 32'(gsp), 32'(esp));
        chk("R8", "ie_set at done", 32'(gie), 32'(eie));
        chk("R10", "pair_we at done", 32'(gwe), 32'(ewe));
        if (ewe) chk("R10", "pair_out", 32'(gpair), 32'(epair));
        if (pk) chk("R12", "start ignored while busy", 32'(gpc), 32'(epc));
        @(negedge clk);
        chk("R12", "done one cycle", 32'(done), 32'd0);
        chk("R12", "idle after done", 32'(busy), 32'd0);
        chk("R8", "ie_set quiet after done", 32'(ie_set), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        errs++; total++;
        $display("FAIL R12 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(16'(i));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        chk("R1", "done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pc_out after reset", 32'(pc_o), 32'd0);
        chk("R1", "sp_out after reset", 32'(sp_o), 32'd0);
        chk("R1", "strobes after reset", {30'd0, mem_rd, mem_wr}, 32'd0);
        chk("R1", "busy after reset", 32'(busy), 32'd0);

        // Sweep every operation, condition code and flag pair.
        for (int o = 0; o < 8; o++)
            for (int c = 0; c < 8; c++)
                for (int zc = 0; zc < 4; zc++)
                    run_op(o, c, zc[1], zc[0], zc[0], c[0],
                           {8'(o * 8 + c), 8'(c * 8 + zc * 2)},
                           {8'(8'hA0 + zc), 8'(8'h90 + c * 4)},
                           {8'h5A ^ 8'(c), 8'(8'hC3 + zc * 16)},
                           tag_of(o));

        // R11: wrap-around corners.
        run_op(1, 0, 0, 0, 0, 0, 16'hFFFA, 16'h8080, 16'h0000, "R11");
        run_op(1, 0, 0, 0, 0, 0, 16'h0005, 16'h8080, 16'h0000, "R11");
        run_op(6, 0, 0, 0, 0, 0, 16'h4040, 16'h0001, 16'hA55A, "R11");
        run_op(7, 0, 0, 0, 1, 0, 16'h4040, 16'hFFFF, 16'h0000, "R11");
        run_op(3, 0, 0, 0, 0, 0, 16'h3050, 16'h0000, 16'h0000, "R11");
        run_op(3, 1, 0, 0, 0, 0, 16'hFFFF, 16'h8080, 16'h0000, "R11");
        run_op(4, 0, 0, 0, 0, 0, 16'h4040, 16'hFFFF, 16'h0000, "R11");
        run_op(0, 0, 0, 0, 0, 0, 16'hFFFF, 16'h8080, 16'h0000, "R11");

        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end
endmodule